// File: doc/BRIEF.md
# I2C Stuck-Data-Line Recovery Controller

This block sits next to an I2C master and frees a bus that a slave is holding low. The usual cause is a master that was reset or interrupted in the middle of a read. The slave is then still waiting to shift out the rest of a byte and keeps SDA at 0. On a start request, or by itself when the master reports the bus idle while SDA reads low, the controller takes the bus. It releases SDA and clocks the slave forward one SCL pulse at a time, reading SDA after every pulse. As soon as SDA reads high, it builds a STOP condition, checks that both lines float high, and hands the bus back.

Both lines are driven open-drain. A drive-enable output of 1 pulls the line low, and 0 releases it. Both lines are read back through a two-stage synchronizer. Each SCL low phase and each SCL high phase lasts a programmable number of system clocks. Before the high phase is timed, the controller waits for SCL to read high, so a slave that stretches the clock is honoured. A round ends with a STOP, or after 9 pulses that leave SDA still low. If SDA is still held after the allowed number of rounds, the controller reports failure and leaves both lines released.

Top module: `busfree_ctrl`

## Requirements
- R1: While reset is high and on the first clock after it, both drive enables, busy, done and fail are 0.
- R2: When idle, a 1 on start_i at a clock edge sets busy_o at that same edge, so it reads 1 one cycle later.
- R3: Every recovery pulse drives SCL low (scl_oe_o = 1) for exactly max(div_i, 4) system clocks while SDA stays released. div_i is latched when the recovery begins.
- R4: After each pulse, SDA is read. Pulsing stops at the first read of 1, so the number of SCL rising edges with SDA released equals the number of low bits the slave still had to send.
- R5: The controller never creates a START. It pulls SDA low only while it holds SCL low. The STOP is made by releasing SCL and then releasing SDA while SCL reads high.
- R6: A round has at most 9 pulses. If SDA still reads 0 after the 9th pulse, a new round starts with SDA released, provided rounds remain.
- R7: A recovery allows max(rounds_i, 1) rounds. If none of them succeeds, fail_o pulses for one cycle and both lines are left released.
- R8: done_o pulses for one cycle only if, after a STOP, both lines read high. If SDA reads low there instead, the next round starts or the recovery fails. done_o and fail_o never occur together, and busy_o falls in the same cycle as either of them.
- R9: A start request that arrives while busy has no effect. busy_o is 0 a few cycles after done, even though a request was made mid-recovery.
- R10: The SCL high phase is timed from the moment SCL actually reads high. A slave stretching the clock therefore lengthens the phase, and it never shortens below max(div_i, 4) clocks of high bus.
- R11: With idle_i = 1, a synchronized SDA reading of 0 starts a recovery without a start request. busy_o rises within 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a recovery (one-cycle pulse) |
| idle_i | input | 1 | Master reports the bus should be idle; enables automatic trigger |
| div_i | input | DIV_W | SCL half-period in system clocks (values below 4 act as 4) |
| rounds_i | input | RND_W | Allowed recovery rounds (0 acts as 1) |
| scl_i | input | 1 | SCL level read from the pad |
| sda_i | input | 1 | SDA level read from the pad |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle pulse: bus freed |
| fail_o | output | 1 | One-cycle pulse: bus still stuck after all rounds |

## Verification
busy_o is sampled one cycle after a start request and within four cycles of an automatic trigger. That allows for the two synchronizer stages plus the output register. Because the completion time depends on the stuck bit count, stretching and divider, done and fail are awaited cycle by cycle, and the bus state is checked in the very cycle the pulse appears. A slave model counts SCL rising edges and releases SDA after its programmed bits. Monitors measure every SCL low and high run on the modelled bus at the falling clock edge and compare it to the latched divider. The expected pulse count, STOP count and outcome come from a bench function that walks the rounds.

// File: rtl/busfree_pkg.sv
`timescale 1ns/1ps
package busfree_pkg;

  // Controller states for one recovery.
  typedef enum logic [3:0] {
    S_IDLE,  // bus handed back, waiting for a request
    S_REL,   // both lines released, settle one half-period
    S_EVAL,  // read SDA, choose pulse / stop / next round
    S_LOW,   // SCL held low for one half-period
    S_HIGH,  // SCL released, timed once it reads high
    S_SA,    // stop: SCL low, SDA released
    S_SB,    // stop: SCL low, SDA low
    S_SC,    // stop: SCL released, SDA low
    S_SD,    // stop: SDA released while SCL high
    S_VER    // both lines must read high
  } rec_state_t;

  // Shortest half-period that leaves room for the input synchronizer.
  localparam int MIN_HALF = 4;

endpackage

// File: rtl/busfree_sync.sv
`timescale 1ns/1ps
module busfree_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  // One shift chain per line; idle bus level is high.
  for (genvar b = 0; b < WIDTH; b++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '1;
      else     chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/busfree_timer.sv
`timescale 1ns/1ps
module busfree_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         run_i,
  input  logic [W-1:0] period_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  // Loading period-1 makes a state last exactly "period" running cycles.
  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (load_i)              cnt_q <= period_i - 1'b1;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = run_i && (cnt_q == '0);

endmodule

// File: rtl/busfree_seq.sv
`timescale 1ns/1ps
module busfree_seq
  import busfree_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int RND_W      = 4,
  parameter int MAX_PULSES = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             idle_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [RND_W-1:0] rounds_i,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             tmr_exp_i,
  output logic             tmr_load_o,
  output logic             tmr_run_o,
  output logic [DIV_W-1:0] tmr_period_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o
);

  localparam int PW  = $clog2(MAX_PULSES + 1);
  localparam int RW1 = RND_W + 1;
  localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_HALF);
  localparam logic [PW-1:0]    PULSE_LIM = PW'(MAX_PULSES);

  rec_state_t       state_q, state_d;
  logic [PW-1:0]    pcnt_q;
  logic [RND_W-1:0] rcnt_q;
  logic [RND_W-1:0] rlim_q;
  logic [DIV_W-1:0] div_q;

  logic             go;
  logic             last_round;
  logic             fin_ok, fin_bad, pulse_inc, new_round;
  logic [DIV_W-1:0] div_eff;
  logic [RND_W-1:0] rlim_eff;

  assign go       = start_i || (idle_i && !sda_s);
  assign div_eff  = (div_i < DIV_FLOOR) ? DIV_FLOOR : div_i;
  assign rlim_eff = (rounds_i == '0) ? RND_W'(1) : rounds_i;
  assign last_round = (RW1'(rcnt_q) + RW1'(1)) >= RW1'(rlim_q);

  // Next-state logic.
  always_comb begin
    state_d   = state_q;
    fin_ok    = 1'b0;
    fin_bad   = 1'b0;
    pulse_inc = 1'b0;
    new_round = 1'b0;
    unique case (state_q)
      S_IDLE: if (go) state_d = S_REL;
      S_REL:  if (tmr_exp_i) state_d = S_EVAL;
      S_EVAL: begin
        if (sda_s) begin
          state_d = S_SA;
        end else if (pcnt_q == PULSE_LIM) begin
          if (last_round) begin
            fin_bad = 1'b1;
            state_d = S_IDLE;
          end else begin
            new_round = 1'b1;
            state_d   = S_REL;
          end
        end else begin
          state_d = S_LOW;
        end
      end
      S_LOW:  if (tmr_exp_i) state_d = S_HIGH;
      S_HIGH: if (tmr_exp_i) begin
        pulse_inc = 1'b1;
        state_d   = S_EVAL;
      end
      S_SA:   if (tmr_exp_i) state_d = S_SB;
      S_SB:   if (tmr_exp_i) state_d = S_SC;
      S_SC:   if (tmr_exp_i) state_d = S_SD;
      S_SD:   if (tmr_exp_i) state_d = S_VER;
      S_VER: begin
        if (scl_s && sda_s) begin
          fin_ok  = 1'b1;
          state_d = S_IDLE;
        end else if (last_round) begin
          fin_bad = 1'b1;
          state_d = S_IDLE;
        end else begin
          new_round = 1'b1;
          state_d   = S_REL;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // Timer control: restart on every state change; high phases wait for SCL.
  assign tmr_load_o   = (state_d != state_q);
  assign tmr_run_o    = (state_q == S_HIGH || state_q == S_SC) ? scl_s : 1'b1;
  assign tmr_period_o = (state_q == S_IDLE) ? div_eff : div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      pcnt_q  <= '0;
      rcnt_q  <= '0;
      rlim_q  <= RND_W'(1);
      div_q   <= DIV_FLOOR;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && go) begin
        pcnt_q <= '0;
        rcnt_q <= '0;
        rlim_q <= rlim_eff;
        div_q  <= div_eff;
      end else if (new_round) begin
        pcnt_q <= '0;
        rcnt_q <= rcnt_q + 1'b1;
      end else if (pulse_inc) begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  // Registered pad enables and status, derived from the next state.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_oe_o <= 1'b0;
      sda_oe_o <= 1'b0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      fail_o   <= 1'b0;
    end else begin
      scl_oe_o <= (state_d == S_LOW) || (state_d == S_SA) || (state_d == S_SB);
      sda_oe_o <= (state_d == S_SB) || (state_d == S_SC);
      busy_o   <= (state_d != S_IDLE);
      done_o   <= fin_ok;
      fail_o   <= fin_bad;
    end
  end

endmodule

// File: rtl/busfree_ctrl.sv
`timescale 1ns/1ps
module busfree_ctrl #(
  parameter int DIV_W       = 16,
  parameter int RND_W       = 4,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             idle_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [RND_W-1:0] rounds_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o
);

  logic [1:0]       pads_s;
  logic             tmr_load, tmr_run, tmr_exp;
  logic [DIV_W-1:0] tmr_period;

  busfree_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({scl_i, sda_i}),
    .q_o (pads_s)
  );

  busfree_timer #(.W(DIV_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .run_i     (tmr_run),
    .period_i  (tmr_period),
    .expired_o (tmr_exp)
  );

  busfree_seq #(.DIV_W(DIV_W), .RND_W(RND_W), .MAX_PULSES(MAX_PULSES)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .idle_i       (idle_i),
    .div_i        (div_i),
    .rounds_i     (rounds_i),
    .scl_s        (pads_s[1]),
    .sda_s        (pads_s[0]),
    .tmr_exp_i    (tmr_exp),
    .tmr_load_o   (tmr_load),
    .tmr_run_o    (tmr_run),
    .tmr_period_o (tmr_period),
    .scl_oe_o     (scl_oe_o),
    .sda_oe_o     (sda_oe_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fail_o       (fail_o)
  );

endmodule

// File: rtl/busfree_chk.sv
`timescale 1ns/1ps
module busfree_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic busy_o,
  input logic done_o,
  input logic fail_o
);

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!scl_oe_o && !sda_oe_o && !busy_o && !done_o && !fail_o));

  // R2
  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> busy_o);

  // R5: SDA only starts being pulled while SCL is pulled
  a_r5_no_start: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> scl_oe_o);

  // R5: lines are left alone outside a recovery
  a_r5_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));

  // R7
  a_r7_fail_released: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> (!scl_oe_o && !sda_oe_o && !busy_o));

  // R8
  a_r8_done_released: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!scl_oe_o && !sda_oe_o && !busy_o));

  a_r8_one_outcome: assert property (@(posedge clk) disable iff (rst)
    !(done_o && fail_o));

  a_r8_busy_ends: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (done_o || fail_o));

endmodule

bind busfree_ctrl busfree_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .scl_oe_o (scl_oe_o),
  .sda_oe_o (sda_oe_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .fail_o   (fail_o)
);

// File: tb/sim_busfree_ctrl.sv
`timescale 1ns/1ps
module sim_busfree_ctrl;

  localparam int DIV_W = 16;
  localparam int RND_W = 4;
  localparam int MAXP  = 9;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic             idle_i  = 1'b0;
  logic [DIV_W-1:0] div_i   = 16'd4;
  logic [RND_W-1:0] rounds_i = 4'd1;
  logic             scl_bus, sda_bus;
  logic             scl_oe, sda_oe, busy, done, fail;

  int checks = 0;
  int errors = 0;

  // Bus / slave model state
  int rem = 0;         // low bits the slave still holds
  int restick_v = 0;   // bits to re-hold after the first STOP
  int stretch_v = 0;   // extra low cycles on each SCL release
  int rel_age = 0;
  int cur_div = 4;
  int pulse_cnt = 0, stop_cnt = 0, width_bad = 0, hi_bad = 0;
  int low_len = 0, hi_len = 0;
  bit low_mix = 0, hi_track = 0;
  logic scl_oe_d = 0, sda_oe_d = 0, scl_bus_d = 1;

  always #2.5 clk = ~clk;

  assign scl_bus = !scl_oe && (rel_age >= stretch_v);
  assign sda_bus = !sda_oe && (rem == 0);

  busfree_ctrl u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .idle_i(idle_i),
    .div_i(div_i), .rounds_i(rounds_i), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy),
    .done_o(done), .fail_o(fail)
  );

  // Slave and bus monitors, all on the falling edge.
  always @(negedge clk) begin
    if (scl_bus && !scl_bus_d) begin
      if (rem > 0) rem = rem - 1;
      if (!sda_oe && busy) pulse_cnt++;
    end
    if (sda_oe_d && !sda_oe && scl_bus) begin
      stop_cnt++;
      if (restick_v > 0) begin rem = restick_v; restick_v = 0; end
    end
    if (scl_oe) begin
      low_len++;
      if (sda_oe) low_mix = 1;
    end else if (scl_oe_d) begin
      if (!low_mix && low_len != cur_div) width_bad++;
      low_len = 0;
      low_mix = 0;
    end
    if (scl_bus) begin
      if (!scl_bus_d) begin hi_track = busy; hi_len = 0; end
      hi_len++;
    end else if (scl_bus_d) begin
      if (hi_track && hi_len < cur_div) hi_bad++;
      hi_track = 0;
    end
    if (scl_oe) rel_age = 0; else rel_age++;
    scl_oe_d  = scl_oe;
    sda_oe_d  = sda_oe;
    scl_bus_d = scl_bus;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Walk the rounds to predict outcome, pulse count and STOP count.
  task automatic expect_calc(input int k1, input int k2, input int rn,
                             output bit ok, output int pl, output int st);
    int r_left = k1;
    int again  = k2;
    int lim    = (rn == 0) ? 1 : rn;
    ok = 0; pl = 0; st = 0;
    for (int r = 0; r < lim; r++) begin
      if (r_left > MAXP) begin
        pl += MAXP;
        r_left -= MAXP;
      end else begin
        pl += r_left;
        r_left = 0;
        st++;
        if (again > 0) begin
          r_left = again;
          again = 0;
        end else begin
          ok = 1;
          break;
        end
      end
    end
  endtask

  task automatic run_case(input int dv, input int rn, input int k1, input int k2,
                          input int st, input bit auto_mode);
    bit eok; int epl, est;
    bit seen_done, seen_fail;
    expect_calc(k1, k2, rn, eok, epl, est);
    @(posedge clk);
    rem = k1; restick_v = k2; stretch_v = st;
    div_i = DIV_W'(dv); rounds_i = RND_W'(rn);
    cur_div = (dv < 4) ? 4 : dv;
    pulse_cnt = 0; stop_cnt = 0; width_bad = 0; hi_bad = 0;
    repeat (4) @(negedge clk);
    if (auto_mode) begin
      idle_i = 1'b1;
      repeat (4) @(negedge clk);
      check(busy == 1'b1, "R11 auto trigger busy", int'(busy), 1);
      idle_i = 1'b0;
    end else begin
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    end
    repeat (3) @(negedge clk);
    start_i = 1'b1;            // R9: request while busy
    @(negedge clk);
    start_i = 1'b0;
    seen_done = 0; seen_fail = 0;
    for (int c = 0; c < 50000; c++) begin
      if (done || fail) begin
        seen_done = done; seen_fail = fail;
        check(!scl_oe && !sda_oe, "R7 lines released at end", int'({scl_oe, sda_oe}), 0);
        break;
      end
      @(negedge clk);
    end
    check(seen_done == eok && seen_fail == !eok, "R8 outcome", int'(seen_done), int'(eok));
    check(pulse_cnt == epl, "R4 R6 pulse count", pulse_cnt, epl);
    check(stop_cnt == est, "R5 stop count", stop_cnt, est);
    check(width_bad == 0, "R3 scl low width", width_bad, 0);
    check(hi_bad == 0, "R10 scl high width", hi_bad, 0);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R9 start ignored while busy", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    check(!scl_oe && !sda_oe && !busy && !done && !fail, "R1 reset outputs",
          int'({scl_oe, sda_oe, busy, done, fail}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!scl_oe && !sda_oe && !busy, "R1 after reset", int'({scl_oe, sda_oe, busy}), 0);

    run_case(5, 1, 0, 0, 0, 0);    // R4: nothing stuck, STOP only
    run_case(4, 1, 9, 0, 0, 0);    // R6: worst case in one round
    run_case(6, 2, 12, 0, 0, 0);   // R6: continues into a second round
    run_case(4, 3, 30, 0, 0, 0);   // R7: all rounds stuck
    run_case(4, 0, 10, 0, 0, 0);   // R7: zero rounds acts as one
    run_case(5, 2, 3, 4, 0, 0);    // R8: re-held after STOP, then freed
    run_case(4, 1, 2, 3, 0, 0);    // R8: re-held, no rounds left
    run_case(2, 1, 4, 0, 0, 0);    // R3: divider floor of 4
    run_case(5, 1, 6, 0, 5, 0);    // R10: clock stretching
    run_case(4, 1, 5, 0, 0, 1);    // R11: automatic trigger
    for (int i = 0; i < 8; i++) begin
      run_case(int'($urandom_range(9, 4)), int'($urandom_range(3, 1)),
               int'($urandom_range(20, 0)), int'($urandom_range(5, 0)),
               int'($urandom_range(3, 0)), 1'b0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule